// File: doc/BRIEF.md
# Asynchronous SRAM Byte Read Controller

This block reads single bytes from an external asynchronous static RAM that is wired to general-purpose pins. A user client asks for a read by raising a request with a 20-bit address while the block shows it is ready. The block then drives chip-select, output-enable and the address pins, waits a set number of clock cycles to cover the memory's access time, and samples the 8-bit data bus into a register. When no read is running, the address pins show the address of a second client, and chip-select stays inactive.

Every pin the block drives comes straight from a flip-flop. The state machine chooses between the read address and the other client's address before the register, not after it, so no multiplexer delay adds to the memory access path. The controls and the address stay asserted for one full cycle after the cycle in which the data is sampled. As a result, the clock edge that captures the byte never also releases the chip, and the memory's data hold time is covered. The captured byte is returned with a one-cycle valid pulse. The target clock is about 115 MHz.

Top module: `sram_rd_ctrl`

## Requirements
- R1: While reset is high, sram_cs_n and sram_oe_n are 1, rd_valid is 0 and rd_ready is 1.
- R2: A request is accepted on a rising edge where rd_req and rd_ready are both 1. In the next cycle sram_cs_n and sram_oe_n are 0, sram_addr equals the rd_addr that was sampled, and rd_ready is 0.
- R3: After a request is accepted, sram_cs_n stays 0 and sram_addr stays unchanged for exactly WAIT_CYCLES+1 consecutive cycles. This includes the cycle after the capture edge, so none of these pins changes on the capture edge.
- R4: The byte on sram_dq is sampled on the edge that ends the WAIT_CYCLES-th cycle of pin assertion. rd_data then equals the memory contents at the requested address.
- R5: rd_valid is high for exactly one cycle per read. It is high in the first cycle after sram_cs_n and sram_oe_n return to 1, and never while sram_cs_n is 0.
- R6: A request raised while rd_ready is 0 is ignored. It starts no access and does not change sram_addr, and the number of accesses equals the number of accepted requests.
- R7: In any cycle where sram_cs_n is 1 (after the first cycle out of reset), sram_addr equals the value alt_addr had in the previous cycle.
- R8: sram_oe_n always equals sram_cs_n.
- R9: WAIT_CYCLES values below 1 are treated as 1, and rd_ready returns to 1 in the same cycle rd_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Read request from the user client |
| rd_addr | input | 20 | Byte address for the requested read |
| rd_ready | output | 1 | High when a request can be accepted |
| alt_addr | input | 20 | Address of the second client, shown on the pins while idle |
| rd_valid | output | 1 | One-cycle pulse marking rd_data as new |
| rd_data | output | 8 | Byte captured from the memory |
| sram_addr | output | 20 | Registered address pins |
| sram_cs_n | output | 1 | Registered chip-select, active low |
| sram_oe_n | output | 1 | Registered output-enable, active low |
| sram_dq | input | 8 | Data bus from the memory |

## Verification
Several properties are checked on every cycle:
- the capture edge is followed by a cycle with chip-select still low and the address unchanged;
- the valid pulse lasts one cycle and only appears with the chip released;
- an accepted request loads its address onto the pins;
- an idle controller tracks the other client's address;
- a request made while busy leaves the address alone.

Some behaviour can only be shown by the bench's scenarios, which use a memory model with its own access delay and hold time:
- the byte returned is correct, which fails if the sample is taken too early;
- the total assertion window has the right length;
- the count of accesses equals the count of accepted requests when busy-time requests are added at random.

// File: rtl/sram_rd_pkg.sv
package sram_rd_pkg;

  // sequencer states
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_HOLD   = 2'd2
  } sr_state_e;

  // what the pin register loads on the next edge
  typedef enum logic [1:0] {
    PSEL_KEEP = 2'd0,
    PSEL_REQ  = 2'd1,
    PSEL_ALT  = 2'd2
  } pin_sel_e;

  function automatic int unsigned eff_wait(input int unsigned w);
    return (w < 1) ? 1 : w;
  endfunction

endpackage

// File: rtl/sram_rd_wait_cnt.sv
module sram_rd_wait_cnt #(
  parameter int unsigned WAIT_CYCLES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic step,
  output logic done
);
  import sram_rd_pkg::*;

  localparam int unsigned W_EFF = eff_wait(WAIT_CYCLES);
  localparam int unsigned CNT_W = (W_EFF > 1) ? $clog2(W_EFF) : 1;
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(W_EFF - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= LOAD_VAL;
    end else if (step && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

  // R4: the counter never leaves the configured window
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LOAD_VAL);

  // R4: a load always restarts the full wait
  cnt_load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == LOAD_VAL));

endmodule

// File: rtl/sram_rd_seq.sv
module sram_rd_seq (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd_req,
  input  logic                  wait_done,
  output logic                  ready,
  output logic                  cnt_load,
  output logic                  cnt_step,
  output logic                  cap_en,
  output logic                  release_en,
  output sram_rd_pkg::pin_sel_e pin_sel
);
  import sram_rd_pkg::*;

  sr_state_e state_q, state_d;

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  always_comb begin
    state_d    = state_q;
    pin_sel    = PSEL_KEEP;
    cnt_load   = 1'b0;
    cnt_step   = 1'b0;
    cap_en     = 1'b0;
    release_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (rd_req) begin
          pin_sel  = PSEL_REQ;
          cnt_load = 1'b1;
          state_d  = ST_ACCESS;
        end else begin
          pin_sel  = PSEL_ALT;
        end
      end
      ST_ACCESS: begin
        if (wait_done) begin
          cap_en  = 1'b1;
          state_d = ST_HOLD;
        end else begin
          cnt_step = 1'b1;
        end
      end
      ST_HOLD: begin
        release_en = 1'b1;
        pin_sel    = PSEL_ALT;
        state_d    = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign ready = (state_q == ST_IDLE);

  // R3: capture is always followed by the hold state, never by idle
  cap_then_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cap_en |=> (state_q == ST_HOLD));

  // R9: the hold state lasts a single cycle and hands back to idle
  hold_single_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HOLD) |=> ready);

endmodule

// File: rtl/sram_rd_pinreg.sv
module sram_rd_pinreg #(
  parameter int unsigned ADDR_W = 20
) (
  input  logic                  clk,
  input  logic                  rst,
  input  sram_rd_pkg::pin_sel_e pin_sel,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [ADDR_W-1:0]     alt_addr,
  output logic [ADDR_W-1:0]     pin_addr,
  output logic                  pin_cs_n,
  output logic                  pin_oe_n
);
  import sram_rd_pkg::*;

  // the address choice is made here, ahead of the flops
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_addr <= '0;
      pin_cs_n <= 1'b1;
      pin_oe_n <= 1'b1;
    end else begin
      unique case (pin_sel)
        PSEL_REQ: begin
          pin_addr <= req_addr;
          pin_cs_n <= 1'b0;
          pin_oe_n <= 1'b0;
        end
        PSEL_ALT: begin
          pin_addr <= alt_addr;
          pin_cs_n <= 1'b1;
          pin_oe_n <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R3: while the chip stays selected, the address does not move
  addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!pin_cs_n && (pin_sel == PSEL_KEEP)) |=> (!pin_cs_n && $stable(pin_addr)));

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic              release_en,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] data_out,
  output logic              valid_out
);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_out  <= '0;
      valid_out <= 1'b0;
    end else begin
      if (cap_en) data_out <= bus_in;
      valid_out <= release_en;
    end
  end

  // R4: the returned byte does not change between capture and valid
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (release_en && !cap_en) |=> $stable(data_out));

endmodule

// File: rtl/sram_rd_ctrl.sv
module sram_rd_ctrl #(
  parameter int unsigned ADDR_W      = 20,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned WAIT_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_ready,
  input  logic [ADDR_W-1:0] alt_addr,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_cs_n,
  output logic              sram_oe_n,
  input  logic [DATA_W-1:0] sram_dq
);
  import sram_rd_pkg::*;

  logic     wait_done, cnt_load, cnt_step, cap_en, release_en;
  pin_sel_e pin_sel;

  sram_rd_wait_cnt #(.WAIT_CYCLES(WAIT_CYCLES)) u_wait (
    .clk  (clk),
    .rst  (rst),
    .load (cnt_load),
    .step (cnt_step),
    .done (wait_done)
  );

  sram_rd_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .rd_req     (rd_req),
    .wait_done  (wait_done),
    .ready      (rd_ready),
    .cnt_load   (cnt_load),
    .cnt_step   (cnt_step),
    .cap_en     (cap_en),
    .release_en (release_en),
    .pin_sel    (pin_sel)
  );

  sram_rd_pinreg #(.ADDR_W(ADDR_W)) u_pins (
    .clk      (clk),
    .rst      (rst),
    .pin_sel  (pin_sel),
    .req_addr (rd_addr),
    .alt_addr (alt_addr),
    .pin_addr (sram_addr),
    .pin_cs_n (sram_cs_n),
    .pin_oe_n (sram_oe_n)
  );

  sram_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk        (clk),
    .rst        (rst),
    .cap_en     (cap_en),
    .release_en (release_en),
    .bus_in     (sram_dq),
    .data_out   (rd_data),
    .valid_out  (rd_valid)
  );

  // R3: the capture edge leaves chip-select low and the address unchanged
  capture_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cap_en |=> (!sram_cs_n && !sram_oe_n && $stable(sram_addr)));

  // R5: valid only appears once the chip is released
  valid_release_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (sram_cs_n && sram_oe_n));

  // R5: valid is a single-cycle pulse
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  // R2: an accepted request lands on the pins one cycle later
  launch_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && rd_ready) |=> (!sram_cs_n && !rd_ready && (sram_addr == $past(rd_addr))));

  // R6: a request made while busy does not touch the address
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_ready && !release_en) |=> $stable(sram_addr));

  // R7: an idle controller shows the other client's address
  idle_alt_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_ready && !rd_req) |=> (sram_cs_n && (sram_addr == $past(alt_addr))));

  // R8: chip-select and output-enable move together
  cs_oe_pair_chk: assert property (@(posedge clk) disable iff (rst)
    sram_cs_n == sram_oe_n);

endmodule

// File: tb/sim_sram_rd_ctrl.sv
`timescale 1ns/1ps
module sim_sram_rd_ctrl;
  localparam int AW = 20;
  localparam int DW = 8;
  localparam int WAITC = 3;
  localparam realtime T_ACC  = 20.0;
  localparam realtime T_HOLD = 2.0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_req = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [AW-1:0] alt_addr = '0;
  logic rd_ready, rd_valid, sram_cs_n, sram_oe_n;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] sram_addr;
  logic [DW-1:0] dq = 8'h00;

  int total = 0, fails = 0, issued = 0, runs = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sram_rd_ctrl #(.ADDR_W(AW), .DATA_W(DW), .WAIT_CYCLES(WAITC)) u0 (
    .clk(clk), .rst(rst), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_ready(rd_ready), .alt_addr(alt_addr), .rd_valid(rd_valid),
    .rd_data(rd_data), .sram_addr(sram_addr), .sram_cs_n(sram_cs_n),
    .sram_oe_n(sram_oe_n), .sram_dq(dq)
  );

  function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[3:0]} ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // memory model: old data held for T_HOLD, then junk, then valid data after T_ACC
  int unsigned gen = 0;
  task automatic model_update(input int unsigned g, input logic [AW-1:0] a, input bit en);
    #(T_HOLD);
    if (g == gen) dq = ~mem_byte(a);
    #(T_ACC - T_HOLD);
    if (g == gen && en) dq = mem_byte(a);
  endtask

  always @(sram_addr or sram_cs_n or sram_oe_n) begin
    gen = gen + 1;
    fork
      model_update(gen, sram_addr, !sram_cs_n && !sram_oe_n);
    join_none
  end

  // alternate client address changes randomly
  initial begin
    forever begin
      @(posedge clk); #1;
      alt_addr = AW'($urandom);
    end
  end

  // cycle monitor
  bit started = 0, prev_cs = 1, prev_acc = 0;
  logic [AW-1:0] prev_alt = '0, prev_acc_addr = '0, run_addr = '0;
  int run_len = 0;

  always @(negedge clk) begin
    if (rst) begin
      started = 0;
    end else begin
      if (started) begin
        chk(sram_oe_n == sram_cs_n, "R8 oe follows cs", sram_oe_n, sram_cs_n);
        if (sram_cs_n) chk(sram_addr == prev_alt, "R7 idle address", sram_addr, prev_alt);
        if (prev_acc) chk(!sram_cs_n && !rd_ready && sram_addr == prev_acc_addr,
                          "R2 launch", {sram_cs_n, rd_ready, 10'd0, sram_addr},
                          {12'd0, prev_acc_addr});
        if (!sram_cs_n) begin
          if (prev_cs) begin
            run_addr = sram_addr; run_len = 1; runs++;
          end else begin
            chk(sram_addr == run_addr, "R3 address stable", sram_addr, run_addr);
            run_len++;
          end
          chk(!rd_valid, "R5 no valid while selected", rd_valid, 0);
        end else if (!prev_cs) begin
          chk(run_len == WAITC + 1, "R3 assertion window", run_len, WAITC + 1);
          chk(rd_valid, "R5 valid on release", rd_valid, 1);
          chk(rd_ready, "R9 ready with valid", rd_ready, 1);
          chk(rd_data == mem_byte(run_addr), "R4 returned byte", rd_data, mem_byte(run_addr));
        end else begin
          chk(!rd_valid, "R5 single pulse", rd_valid, 0);
        end
      end
      prev_cs = sram_cs_n;
      prev_alt = alt_addr;
      prev_acc = rd_req && rd_ready;
      prev_acc_addr = rd_addr;
      started = 1;
    end
  end

  task automatic do_read(input logic [AW-1:0] a, input bit noise);
    @(posedge clk); #1;
    rd_req = 1'b1; rd_addr = a;
    while (!rd_ready) begin @(posedge clk); #1; end
    @(posedge clk); #1;
    rd_req = 1'b0; issued++;
    while (!rd_valid) begin
      if (noise && !rd_ready && ($urandom % 2 == 0)) begin
        rd_req = 1'b1; rd_addr = AW'($urandom);
      end
      @(posedge clk); #1;
      rd_req = 1'b0;
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(sram_cs_n && sram_oe_n, "R1 controls inactive", {sram_cs_n, sram_oe_n}, 2'b11);
    chk(!rd_valid, "R1 valid low", rd_valid, 0);
    chk(rd_ready, "R1 ready high", rd_ready, 1);
    @(posedge clk); #1; rst = 1'b0;
    repeat (4) @(posedge clk);
    // directed corners
    do_read(20'h00000, 0);
    do_read(20'hFFFFF, 0);
    do_read(20'h55555, 1);
    do_read(20'hAAAAA, 1);
    // R6 busy requests mixed with random reads
    for (int i = 0; i < 300; i++) begin
      int gap = $urandom % 4;
      repeat (gap) @(posedge clk);
      do_read(AW'($urandom), ($urandom % 3) != 0);
    end
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk(runs == issued, "R6 one access per accepted request", runs, issued);
    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", runs, issued);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule